// File: doc/BRIEF.md
# Arc Suppression and Shutdown Sequencer

This block sits between an arc detector and the power setpoint path of an RF generator. When an arc pulse arrives it drops the output power scale to 70 % of full in the very next clock cycle and holds it there for a suppression interval. After that interval it raises the scale back to full in fixed steps. It then keeps the detector masked for a settling window, so that disturbance from the ramp is not read as a new arc. While this recovery runs it also tells the detector to freeze its slow baseline.

The suppression interval adapts to the load. If the arc input is still high on the last cycle of the settling window, a new suppression starts with twice the previous interval, capped at a ceiling. One clean settle brings the interval back to its base value. The block also tracks how densely arcs arrive. When too many counted arcs fall inside a sliding window, it latches a shutdown with zero power scale. Only an explicit clear ends the shutdown.

Top module: `arc_guard_seq`

## Requirements
- R1: During and right after reset, `pwr_scale` is all ones (full scale), and `bl_freeze`, `det_mask` and `shutdown` are low.
- R2: An arc sampled high while the block is idle sets `pwr_scale` to floor(full×7/10) at that same clock edge (45874 for a 16-bit scale) and raises `bl_freeze`.
- R3: The suppressed level is held for exactly the current interval in cycles, counting the arc's edge as the first cycle. The interval after reset is `SUP_BASE`.
- R4: After suppression, `pwr_scale` rises by `RAMP_STEP` once every `RAMP_DIV` cycles, with the first step `RAMP_DIV` cycles after suppression ends. It saturates at full scale.
- R5: One cycle after full scale is reached, `det_mask` goes high for `SETTLE_CYC` cycles. Arcs sampled while it is high have no effect except on the last settle cycle. After a clean settle, `bl_freeze` and `det_mask` drop together.
- R6: An arc sampled on the last settle cycle starts a new suppression at once. Its interval is twice the previous one, saturating at `SUP_MAX`.
- R7: A settle that ends with no arc returns the interval to `SUP_BASE`.
- R8: An arc sampled during the ramp cuts the scale back to the suppressed level at that edge, and the interval is left unchanged.
- R9: Arcs are counted when taken in idle, during the ramp or at the end of a settle. A counted arc whose `ARC_TRIP-1` predecessors are all younger than `WINDOW_CYC` cycles enters shutdown instead: `pwr_scale` is 0, `shutdown` is high, and `bl_freeze` and `det_mask` are low.
- R10: Shutdown ignores arcs and stays latched until `clr` is sampled high. The clear returns the block to idle at full scale and empties the arc history. Outside shutdown, `clr` has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arc_in | input | 1 | Arc indication from the detector, sampled each edge |
| clr | input | 1 | Releases a latched shutdown |
| pwr_scale | output | SCALE_W | Multiplier for the power setpoint, all ones = full |
| bl_freeze | output | 1 | Freeze request for the detector's slow baseline |
| det_mask | output | 1 | Masks arc detection during settling |
| shutdown | output | 1 | Latched shutdown indication |

## Verification
Every output is a register, so the cut to the suppressed level, the entry into shutdown and the effect of a clear all appear at the same edge that samples the input. The bench therefore expects them at cycle P for a stimulus sampled at edge P. From an arc at P with interval I, the last suppressed cycle is P+I-1 and the first ramp step is at P+I+RAMP_DIV. Full scale is reached n·RAMP_DIV cycles after suppression ends, the mask covers the next SETTLE_CYC cycles, and idle follows. The bench derives each of these cycle numbers from the parameters and queues them as expectations. A monitor compares them half a cycle after the edge they belong to, so a result one cycle early or late is reported.

// File: rtl/arc_guard_pkg.sv
package arc_guard_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SUPP   = 3'd1,
      ST_RAMP   = 3'd2,
      ST_SETTLE = 3'd3,
      ST_SHUT   = 3'd4
   } guard_st_t;

   typedef enum logic [2:0] {
      SC_HOLD = 3'd0,
      SC_CUT  = 3'd1,
      SC_OFF  = 3'd2,
      SC_RUN  = 3'd3,
      SC_FULL = 3'd4
   } scale_op_t;

   // suppressed level: 70 % of full scale, rounded down
   function automatic int unsigned cut_level(int unsigned w);
      int unsigned full_v;
      full_v = (32'd1 << w) - 32'd1;
      return (full_v * 32'd7) / 32'd10;
   endfunction

endpackage

// File: rtl/arc_guard_ramp.sv
module arc_guard_ramp
   import arc_guard_pkg::*;
#(
   parameter int unsigned SCALE_W   = 16,
   parameter int unsigned RAMP_STEP = 4096,
   parameter int unsigned RAMP_DIV  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  scale_op_t          op_i,
   output logic [SCALE_W-1:0] scale_o,
   output logic               at_full_o
);

   localparam logic [SCALE_W-1:0] FULL_S = {SCALE_W{1'b1}};
   localparam logic [SCALE_W-1:0] CUT_S  = SCALE_W'(cut_level(SCALE_W));

   if (RAMP_STEP < 1 || RAMP_STEP > ((32'd1 << SCALE_W) - 1)) begin : g_bad_step
      $error("arc_guard_ramp: RAMP_STEP out of range");
   end
   if (RAMP_DIV < 1) begin : g_bad_div
      $error("arc_guard_ramp: RAMP_DIV must be at least 1");
   end

   logic [SCALE_W-1:0] scale_q;
   logic [SCALE_W:0]   sum_w;
   logic               tick;

   if (RAMP_DIV == 1) begin : g_every_cycle
      assign tick = 1'b1;
   end else begin : g_divided
      localparam int unsigned DIV_W = $clog2(RAMP_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(RAMP_DIV - 1);
      logic [DIV_W-1:0] div_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            div_q <= '0;
         end else if (op_i != SC_RUN || div_q == DIV_LAST) begin
            div_q <= '0;
         end else begin
            div_q <= div_q + DIV_W'(1);
         end
      end

      assign tick = (div_q == DIV_LAST);
   end

   assign sum_w = {1'b0, scale_q} + (SCALE_W+1)'(RAMP_STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scale_q <= FULL_S;
      end else begin
         case (op_i)
            SC_CUT:  scale_q <= CUT_S;
            SC_OFF:  scale_q <= '0;
            SC_FULL: scale_q <= FULL_S;
            SC_RUN: begin
               if (tick) begin
                  scale_q <= sum_w[SCALE_W] ? FULL_S : sum_w[SCALE_W-1:0];
               end
            end
            default: scale_q <= scale_q;
         endcase
      end
   end

   assign scale_o   = scale_q;
   assign at_full_o = (scale_q == FULL_S);

   AST_RAMP_RISES: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == SC_RUN) |=> (scale_o >= $past(scale_o))); // R4

endmodule

// File: rtl/arc_guard_timer.sv
module arc_guard_timer #(
   parameter int unsigned SUP_BASE   = 8,
   parameter int unsigned SUP_MAX    = 64,
   parameter int unsigned SETTLE_CYC = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ld_sup_i,
   input  logic ld_settle_i,
   input  logic grow_i,
   input  logic shrink_i,
   output logic done_o
);

   localparam int unsigned CNT_MAX = (SUP_MAX > SETTLE_CYC) ? SUP_MAX : SETTLE_CYC;
   localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

   if (SUP_BASE < 1 || SUP_MAX < SUP_BASE) begin : g_bad_int
      $error("arc_guard_timer: need 1 <= SUP_BASE <= SUP_MAX");
   end
   if (SETTLE_CYC < 1) begin : g_bad_settle
      $error("arc_guard_timer: SETTLE_CYC must be at least 1");
   end

   logic [CNT_W-1:0] cur_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] nxt_int;
   logic [CNT_W:0]   dbl_w;

   assign dbl_w = {cur_q, 1'b0};

   always_comb begin
      nxt_int = cur_q;
      if (grow_i) begin
         nxt_int = (dbl_w > (CNT_W+1)'(SUP_MAX)) ? CNT_W'(SUP_MAX) : dbl_w[CNT_W-1:0];
      end else if (shrink_i) begin
         nxt_int = CNT_W'(SUP_BASE);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= CNT_W'(SUP_BASE);
         cnt_q <= '0;
      end else begin
         cur_q <= nxt_int;
         if (ld_sup_i) begin
            cnt_q <= nxt_int - CNT_W'(1);
         end else if (ld_settle_i) begin
            cnt_q <= CNT_W'(SETTLE_CYC - 1);
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   assign done_o = (cnt_q == '0);

   AST_INT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_q >= CNT_W'(SUP_BASE)) && (cur_q <= CNT_W'(SUP_MAX))); // R6

endmodule

// File: rtl/arc_guard_hist.sv
module arc_guard_hist #(
   parameter int unsigned ARC_TRIP   = 4,
   parameter int unsigned WINDOW_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic push_i,
   input  logic flush_i,
   output logic trip_o
);

   localparam int unsigned ENT   = ARC_TRIP - 1;
   localparam int unsigned WIN_W = $clog2(WINDOW_CYC + 1);
   localparam logic [WIN_W-1:0] WIN_L = WIN_W'(WINDOW_CYC);

   if (ARC_TRIP < 2) begin : g_bad_trip
      $error("arc_guard_hist: ARC_TRIP must be at least 2");
   end
   if (WINDOW_CYC < 1) begin : g_bad_win
      $error("arc_guard_hist: WINDOW_CYC must be at least 1");
   end

   // age of each remembered arc in cycles, saturating at the window length
   logic [WIN_W-1:0] age_q [ENT];
   logic [WIN_W-1:0] aged  [ENT];
   logic [ENT-1:0]   vld_q;

   always_comb begin
      for (int i = 0; i < ENT; i++) begin
         aged[i] = (age_q[i] == WIN_L) ? WIN_L : age_q[i] + WIN_W'(1);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         for (int i = 0; i < ENT; i++) age_q[i] <= '0;
      end else if (flush_i) begin
         vld_q <= '0;
         for (int i = 0; i < ENT; i++) age_q[i] <= '0;
      end else if (push_i) begin
         vld_q[0] <= 1'b1;
         age_q[0] <= '0;
         for (int i = 1; i < ENT; i++) begin
            vld_q[i] <= vld_q[i-1];
            age_q[i] <= aged[i-1];
         end
      end else begin
         for (int i = 0; i < ENT; i++) age_q[i] <= aged[i];
      end
   end

   assign trip_o = push_i && vld_q[ENT-1] && (age_q[ENT-1] < WIN_L);

   AST_AGE_CAPPED: assert property (@(posedge clk) disable iff (!rst_n)
      age_q[ENT-1] <= WIN_L); // R9

endmodule

// File: rtl/arc_guard_seq.sv
module arc_guard_seq
   import arc_guard_pkg::*;
#(
   parameter int unsigned SCALE_W    = 16,
   parameter int unsigned SUP_BASE   = 8,
   parameter int unsigned SUP_MAX    = 64,
   parameter int unsigned SETTLE_CYC = 6,
   parameter int unsigned RAMP_STEP  = 4096,
   parameter int unsigned RAMP_DIV   = 4,
   parameter int unsigned ARC_TRIP   = 4,
   parameter int unsigned WINDOW_CYC = 1_000_000_000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               arc_in,
   input  logic               clr,
   output logic [SCALE_W-1:0] pwr_scale,
   output logic               bl_freeze,
   output logic               det_mask,
   output logic               shutdown
);

   localparam logic [SCALE_W-1:0] CUT_S = SCALE_W'(cut_level(SCALE_W));

   if (SCALE_W < 4 || SCALE_W > 24) begin : g_bad_width
      $error("arc_guard_seq: SCALE_W must lie in 4..24");
   end

   guard_st_t st_q, st_d;
   scale_op_t op;
   logic push, flush, ld_sup, ld_settle, grow, shrink;
   logic trip, done, at_full;

   // a counted arc either trips the density guard or starts a suppression
   always_comb begin
      st_d      = st_q;
      op        = SC_HOLD;
      push      = 1'b0;
      flush     = 1'b0;
      ld_sup    = 1'b0;
      ld_settle = 1'b0;
      grow      = 1'b0;
      shrink    = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (arc_in) begin
               push = 1'b1;
               if (trip) begin
                  st_d = ST_SHUT;
                  op   = SC_OFF;
               end else begin
                  st_d   = ST_SUPP;
                  op     = SC_CUT;
                  ld_sup = 1'b1;
               end
            end
         end
         ST_SUPP: begin
            if (done) st_d = ST_RAMP;
         end
         ST_RAMP: begin
            if (arc_in) begin
               push = 1'b1;
               if (trip) begin
                  st_d = ST_SHUT;
                  op   = SC_OFF;
               end else begin
                  st_d   = ST_SUPP;
                  op     = SC_CUT;
                  ld_sup = 1'b1;
               end
            end else begin
               op = SC_RUN;
               if (at_full) begin
                  st_d      = ST_SETTLE;
                  ld_settle = 1'b1;
               end
            end
         end
         ST_SETTLE: begin
            if (done) begin
               if (arc_in) begin
                  push = 1'b1;
                  if (trip) begin
                     st_d = ST_SHUT;
                     op   = SC_OFF;
                  end else begin
                     st_d   = ST_SUPP;
                     op     = SC_CUT;
                     ld_sup = 1'b1;
                     grow   = 1'b1;
                  end
               end else begin
                  st_d   = ST_IDLE;
                  shrink = 1'b1;
               end
            end
         end
         ST_SHUT: begin
            if (clr) begin
               st_d  = ST_IDLE;
               op    = SC_FULL;
               flush = 1'b1;
            end
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   arc_guard_ramp #(
      .SCALE_W  (SCALE_W),
      .RAMP_STEP(RAMP_STEP),
      .RAMP_DIV (RAMP_DIV)
   ) u_ramp (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_i     (op),
      .scale_o  (pwr_scale),
      .at_full_o(at_full)
   );

   arc_guard_timer #(
      .SUP_BASE  (SUP_BASE),
      .SUP_MAX   (SUP_MAX),
      .SETTLE_CYC(SETTLE_CYC)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .ld_sup_i   (ld_sup),
      .ld_settle_i(ld_settle),
      .grow_i     (grow),
      .shrink_i   (shrink),
      .done_o     (done)
   );

   arc_guard_hist #(
      .ARC_TRIP  (ARC_TRIP),
      .WINDOW_CYC(WINDOW_CYC)
   ) u_hist (
      .clk    (clk),
      .rst_n  (rst_n),
      .push_i (push),
      .flush_i(flush),
      .trip_o (trip)
   );

   assign bl_freeze = (st_q == ST_SUPP) || (st_q == ST_RAMP) || (st_q == ST_SETTLE);
   assign det_mask  = (st_q == ST_SETTLE);
   assign shutdown  = (st_q == ST_SHUT);

   AST_CUT_ON_ARC: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_IDLE && arc_in && !trip) |=> (pwr_scale == CUT_S)); // R2

   AST_MASK_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      det_mask |-> (&pwr_scale)); // R5

   AST_SHUT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown |-> (pwr_scale == '0)); // R9

   AST_SHUT_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
      (shutdown && !clr) |=> shutdown); // R10

endmodule

// File: tb/arc_guard_seq_tb.sv
`timescale 1ns/1ps
module arc_guard_seq_tb;

   localparam int FULL   = 65535;
   localparam int CUT    = (FULL * 7) / 10;
   localparam int STEP   = 4096;
   localparam int DIV    = 4;
   localparam int SETTLE = 6;
   localparam int NSTEP  = (FULL - CUT + STEP - 1) / STEP;

   typedef struct {
      int          cyc;
      logic [15:0] sc;
      logic        frz;
      logic        msk;
      logic        sd;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n, arc_in, clr;
   logic [15:0] pwr_scale;
   logic        bl_freeze, det_mask, shutdown;

   int   cyc = 0;
   int   n_chk = 0;
   int   n_err = 0;
   bit   finished = 1'b0;
   exp_t sb_q[$];
   exp_t mon_it;

   arc_guard_seq #(
      .SCALE_W   (16),
      .SUP_BASE  (8),
      .SUP_MAX   (32),
      .SETTLE_CYC(SETTLE),
      .RAMP_STEP (STEP),
      .RAMP_DIV  (DIV),
      .ARC_TRIP  (4),
      .WINDOW_CYC(120)
   ) u_dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .arc_in   (arc_in),
      .clr      (clr),
      .pwr_scale(pwr_scale),
      .bl_freeze(bl_freeze),
      .det_mask (det_mask),
      .shutdown (shutdown)
   );

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // driver side: queue an expectation, kept sorted by cycle
   function automatic void expect_at(int c, int sc, bit f, bit m, bit s, string tag);
      exp_t it;
      int   idx;
      it.cyc = c; it.sc = 16'(sc); it.frz = f; it.msk = m; it.sd = s; it.tag = tag;
      idx = sb_q.size();
      for (int i = 0; i < sb_q.size(); i++) begin
         if (sb_q[i].cyc > c) begin
            idx = i;
            break;
         end
      end
      sb_q.insert(idx, it);
   endfunction

   // one suppression-ramp-settle episode for an arc taken at edge p, interval iv
   function automatic int expect_episode(int p, int iv);
      int tf;
      tf = p + iv + NSTEP * DIV;
      expect_at(p,                CUT,                        1, 0, 0, "R2");
      expect_at(p + iv - 1,       CUT,                        1, 0, 0, "R3");
      expect_at(p + iv + DIV - 1, CUT,                        1, 0, 0, "R3");
      expect_at(p + iv + DIV,     CUT + STEP,                 1, 0, 0, "R4");
      expect_at(tf - 1,           CUT + (NSTEP - 1) * STEP,   1, 0, 0, "R4");
      expect_at(tf,               FULL,                       1, 0, 0, "R4");
      expect_at(tf + 1,           FULL,                       1, 1, 0, "R5");
      expect_at(tf + SETTLE,      FULL,                       1, 1, 0, "R5");
      return tf + 1 + SETTLE;
   endfunction

   task automatic wait_until(int c);
      while (cyc < c) @(negedge clk);
   endtask

   task automatic arc_at(int e);
      wait_until(e - 1);
      arc_in = 1'b1;
      wait_until(e);
      arc_in = 1'b0;
   endtask

   task automatic clr_at(int e);
      wait_until(e - 1);
      clr = 1'b1;
      wait_until(e);
      clr = 1'b0;
   endtask

   // monitor side: compare each expectation half a cycle after its edge
   always @(negedge clk) begin
      while (sb_q.size() > 0 && sb_q[0].cyc <= cyc) begin
         mon_it = sb_q.pop_front();
         n_chk++;
         if (mon_it.cyc < cyc) begin
            n_err++;
            $display("FAIL %s cycle %0d: actual missed (now %0d) expected sampled", mon_it.tag, mon_it.cyc, cyc);
         end else if (pwr_scale !== mon_it.sc || bl_freeze !== mon_it.frz ||
                      det_mask !== mon_it.msk || shutdown !== mon_it.sd) begin
            n_err++;
            $display("FAIL %s cycle %0d: actual scale=%0d frz=%b msk=%b sd=%b expected scale=%0d frz=%b msk=%b sd=%b",
                     mon_it.tag, cyc, pwr_scale, bl_freeze, det_mask, shutdown,
                     mon_it.sc, mon_it.frz, mon_it.msk, mon_it.sd);
         end
      end
   end

   initial begin
      int t;
      rst_n  = 1'b0;
      arc_in = 1'b0;
      clr    = 1'b0;

      // R1: reset state, during and after reset
      expect_at(2, FULL, 0, 0, 0, "R1");
      expect_at(4, FULL, 0, 0, 0, "R1");

      // clean episode with base interval; masked arc ignored (R5)
      t = expect_episode(10, 8);
      expect_at(42, FULL, 1, 1, 0, "R5");
      expect_at(t, FULL, 0, 0, 0, "R5");

      // persistent arc at settle end doubles, then saturates at 32 (R6)
      t = expect_episode(60, 8);       // ends 95
      t = expect_episode(95, 16);      // ends 138
      expect_at(110, CUT, 1, 0, 0, "R6");
      expect_at(114, CUT, 1, 0, 0, "R6");
      t = expect_episode(138, 32);     // ends 197
      t = expect_episode(197, 32);     // ends 256
      expect_at(228, CUT, 1, 0, 0, "R6");
      expect_at(232, CUT, 1, 0, 0, "R6");
      expect_at(233, CUT + STEP, 1, 0, 0, "R6");
      expect_at(t, FULL, 0, 0, 0, "R7");

      // after a clean settle the interval is back at base (R7); clr ignored (R10)
      t = expect_episode(300, 8);
      expect_at(304, CUT, 1, 0, 0, "R10");
      expect_at(311, CUT, 1, 0, 0, "R7");
      expect_at(312, CUT + STEP, 1, 0, 0, "R7");
      expect_at(t, FULL, 0, 0, 0, "R7");

      // dense arcs: A idle, B and C in ramp, D trips (R8, R9)
      expect_at(500, CUT, 1, 0, 0, "R2");
      expect_at(512, CUT + STEP, 1, 0, 0, "R4");
      expect_at(513, CUT, 1, 0, 0, "R8");
      expect_at(524, CUT, 1, 0, 0, "R8");
      expect_at(525, CUT + STEP, 1, 0, 0, "R8");
      expect_at(526, CUT, 1, 0, 0, "R9");
      expect_at(536, 0, 0, 0, 1, "R9");
      expect_at(541, 0, 0, 0, 1, "R10");
      expect_at(560, 0, 0, 0, 1, "R10");
      expect_at(570, FULL, 0, 0, 0, "R10");
      t = expect_episode(572, 8);
      expect_at(573, CUT, 1, 0, 0, "R10");
      expect_at(t, FULL, 0, 0, 0, "R10");

      wait_until(3);
      rst_n = 1'b1;

      arc_at(10);
      arc_at(41);
      arc_at(60);
      arc_at(95);
      arc_at(138);
      arc_at(197);
      arc_at(300);
      clr_at(303);
      arc_at(500);
      arc_at(513);
      arc_at(526);
      arc_at(536);
      arc_at(540);
      clr_at(570);
      arc_at(572);

      wait_until(640);
      while (sb_q.size() > 0) begin
         mon_it = sb_q.pop_front();
         n_chk++;
         n_err++;
         $display("FAIL %s cycle %0d: actual never checked expected scale=%0d", mon_it.tag, mon_it.cyc, mon_it.sc);
      end
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual cycle %0d expected run complete", cyc);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

endmodule